// File: doc/BRIEF.md
# Indirect Pointer Register Unit

This block is a 32-entry, 8-bit general register file whose top six locations also act as three 16-bit data-space address pointers. Any register can be read or written one byte at a time by its index. Alongside that byte port, an effective-address port takes a pointer select, an addressing mode and a small unsigned offset. It returns the 16-bit address for the current access in the same cycle.

When the mode asks for it, the port also writes the updated pointer back into its register pair. That write-back happens at the next clock edge. The modes are: plain use of the pointer, pointer plus offset, use-then-increment, and decrement-then-use. All pointer arithmetic wraps modulo 2^16, so a carry or borrow crosses from the low byte into the high byte.

Top module: `ptr_reg_unit`

## Requirements
- R1: After reset every one of the 32 registers reads as 0x00.
- R2: `rd_data` shows the register chosen by `rd_idx` combinationally. A byte written through `wr_en`/`wr_idx`/`wr_data` becomes readable one clock edge later.
- R3: Pointer select 0 chooses the pair {r27 high, r26 low}. Select 1 chooses {r29, r28} and select 2 chooses {r31, r30}. In plain mode (mode code 0) `ea_addr` equals the pointer, and the pointer is left unchanged.
- R4: In offset mode (mode code 1), `ea_addr` equals the pointer plus the zero-extended 6-bit `ea_disp`, modulo 2^16. The pointer is left unchanged.
- R5: In post-increment mode (mode code 2), `ea_addr` equals the current pointer. After the next edge the pointer holds that value plus one, modulo 2^16, so 0xFFFF becomes 0x0000 and 0x00FF becomes 0x0100.
- R6: In pre-decrement mode (mode code 3), `ea_addr` equals the pointer minus one, modulo 2^16. After the next edge the pointer holds that same value, so 0x0000 gives 0xFFFF and 0x0100 gives 0x00FF.
- R7: When `ea_valid` is low, or the select is 3, `ea_addr` is 0x0000 and no register changes because of the address port.
- R8: If a byte write and a pointer write-back hit the same register in one cycle, the register takes the write-back value. A byte write to any register outside the active pair still takes effect in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Byte write enable |
| wr_idx | input | 5 | Register index for the byte write |
| wr_data | input | 8 | Byte to write |
| rd_idx | input | 5 | Register index for the byte read |
| rd_data | output | 8 | Byte read, combinational |
| ea_valid | input | 1 | Address request this cycle |
| ea_sel | input | 2 | Pointer select: 0, 1, 2; 3 selects none |
| ea_mode | input | 2 | 0 plain, 1 offset, 2 post-increment, 3 pre-decrement |
| ea_disp | input | 6 | Unsigned offset for mode 1 |
| ea_addr | output | 16 | Effective address, combinational |

## Verification
`ea_addr` and `rd_data` are due in the same cycle as their inputs. Register and pointer updates are due after the next rising edge. The bench drives inputs just after a falling edge and samples the combinational outputs a few nanoseconds later, still before the rising edge. Only after that edge does it advance its reference register array, so every read in a later cycle sees the updated state. The checker module registers the request flags and compares the pointer one edge afterwards.

// File: rtl/ptr_unit_pkg.sv
package ptr_unit_pkg;

   typedef enum logic [1:0] {
      EA_PLAIN   = 2'd0,
      EA_OFFSET  = 2'd1,
      EA_POSTINC = 2'd2,
      EA_PREDEC  = 2'd3
   } ea_mode_e;

   // Selects whether pointer arithmetic is one wide adder or two byte
   // adders with an explicit carry between them.
   typedef enum int {
      ADD_WIDE  = 0,
      ADD_SPLIT = 1
   } add_style_e;

endpackage

// File: rtl/ptr_addr_calc.sv
module ptr_addr_calc
   import ptr_unit_pkg::*;
#(
   parameter int DW        = 8,
   parameter int AW        = 16,
   parameter int DISP_W    = 6,
   parameter int ADD_STYLE = ADD_SPLIT
) (
   input  logic [AW-1:0]     ptr_in,
   input  ea_mode_e          mode,
   input  logic [DISP_W-1:0] disp,
   output logic [AW-1:0]     addr,
   output logic [AW-1:0]     ptr_next,
   output logic              need_wb
);

   localparam int HW = AW - DW;

   logic [AW-1:0] operand;
   logic [AW-1:0] sum;

   initial begin
      if (AW != 2 * DW) $fatal(1, "ptr_addr_calc: AW must be twice DW");
      if (DISP_W >= AW) $fatal(1, "ptr_addr_calc: DISP_W too wide");
   end

   // operand is what gets added to the pointer for this mode
   always_comb begin
      unique case (mode)
         EA_OFFSET:  operand = AW'(disp);
         EA_POSTINC: operand = AW'(1);
         EA_PREDEC:  operand = '1;
         default:    operand = '0;
      endcase
   end

   generate
      if (ADD_STYLE == ADD_SPLIT) begin : g_split
         logic [DW:0]   lo_sum;
         logic [HW-1:0] hi_sum;
         always_comb begin
            lo_sum = {1'b0, ptr_in[DW-1:0]} + {1'b0, operand[DW-1:0]};
            hi_sum = ptr_in[AW-1:DW] + operand[AW-1:DW] + HW'(lo_sum[DW]);
         end
         assign sum = {hi_sum, lo_sum[DW-1:0]};
      end else begin : g_wide
         assign sum = ptr_in + operand;
      end
   endgenerate

   always_comb begin
      addr     = ptr_in;
      ptr_next = ptr_in;
      need_wb  = 1'b0;
      unique case (mode)
         EA_PLAIN:   addr = ptr_in;
         EA_OFFSET:  addr = sum;
         EA_POSTINC: begin
            addr     = ptr_in;
            ptr_next = sum;
            need_wb  = 1'b1;
         end
         EA_PREDEC:  begin
            addr     = sum;
            ptr_next = sum;
            need_wb  = 1'b1;
         end
         default:    addr = ptr_in;
      endcase
   end

endmodule

// File: rtl/ptr_reg_bank.sv
module ptr_reg_bank #(
   parameter int NREG     = 32,
   parameter int DW       = 8,
   parameter int AW       = 16,
   parameter int NPTR     = 3,
   parameter int PTR_BASE = 26,
   parameter int IDXW     = $clog2(NREG),
   parameter int SELW     = $clog2(NPTR + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [IDXW-1:0]      wr_idx,
   input  logic [DW-1:0]        wr_data,
   input  logic                 wb_en,
   input  logic [SELW-1:0]      wb_sel,
   input  logic [AW-1:0]        wb_val,
   input  logic [IDXW-1:0]      rd_idx,
   output logic [DW-1:0]        rd_data,
   output logic [NPTR*AW-1:0]   ptr_flat
);

   logic [NREG*DW-1:0] regs_flat;

   initial begin
      if (PTR_BASE + 2 * NPTR > NREG) $fatal(1, "ptr_reg_bank: pointers exceed file");
      if (AW != 2 * DW) $fatal(1, "ptr_reg_bank: AW must be twice DW");
   end

   genvar i;
   generate
      for (i = 0; i < NREG; i++) begin : g_reg
         logic [DW-1:0] q;
         logic          hit_wr;
         assign hit_wr = wr_en && (wr_idx == IDXW'(i));
         if (i >= PTR_BASE && i < PTR_BASE + 2 * NPTR) begin : g_ptr_byte
            localparam int P = (i - PTR_BASE) / 2;
            localparam int B = (i - PTR_BASE) % 2;
            logic hit_wb;
            assign hit_wb = wb_en && (wb_sel == SELW'(P));
            // write-back takes priority over a byte write
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)      q <= '0;
               else if (hit_wb) q <= wb_val[B*DW +: DW];
               else if (hit_wr) q <= wr_data;
            end
         end else begin : g_plain_byte
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)      q <= '0;
               else if (hit_wr) q <= wr_data;
            end
         end
         assign regs_flat[i*DW +: DW] = q;
      end

      for (i = 0; i < NPTR; i++) begin : g_ptr_view
         assign ptr_flat[i*AW +: AW] = {regs_flat[(PTR_BASE+2*i+1)*DW +: DW],
                                        regs_flat[(PTR_BASE+2*i)*DW +: DW]};
      end
   endgenerate

   assign rd_data = regs_flat[rd_idx*DW +: DW];

endmodule

// File: rtl/ptr_reg_unit.sv
module ptr_reg_unit
   import ptr_unit_pkg::*;
#(
   parameter int NREG      = 32,
   parameter int DW        = 8,
   parameter int AW        = 16,
   parameter int NPTR      = 3,
   parameter int PTR_BASE  = 26,
   parameter int DISP_W    = 6,
   parameter int ADD_STYLE = ADD_SPLIT,
   parameter int IDXW      = $clog2(NREG),
   parameter int SELW      = $clog2(NPTR + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDXW-1:0]   wr_idx,
   input  logic [DW-1:0]     wr_data,
   input  logic [IDXW-1:0]   rd_idx,
   output logic [DW-1:0]     rd_data,
   input  logic              ea_valid,
   input  logic [SELW-1:0]   ea_sel,
   input  logic [1:0]        ea_mode,
   input  logic [DISP_W-1:0] ea_disp,
   output logic [AW-1:0]     ea_addr
);

   logic [NPTR*AW-1:0] ptr_flat;
   logic [AW-1:0]      ptr_cur;
   logic [AW-1:0]      calc_addr;
   logic [AW-1:0]      calc_next;
   logic               calc_wb;
   logic               sel_ok;
   logic               wb_en;

   initial begin
      if (NPTR < 1) $fatal(1, "ptr_reg_unit: need at least one pointer");
      if (SELW < 1) $fatal(1, "ptr_reg_unit: select width");
   end

   assign sel_ok = ea_valid && (32'(ea_sel) < NPTR);

   always_comb begin
      ptr_cur = '0;
      for (int p = 0; p < NPTR; p++) begin
         if (ea_sel == SELW'(p)) ptr_cur = ptr_flat[p*AW +: AW];
      end
   end

   ptr_addr_calc #(
      .DW(DW), .AW(AW), .DISP_W(DISP_W), .ADD_STYLE(ADD_STYLE)
   ) u_calc (
      .ptr_in   (ptr_cur),
      .mode     (ea_mode_e'(ea_mode)),
      .disp     (ea_disp),
      .addr     (calc_addr),
      .ptr_next (calc_next),
      .need_wb  (calc_wb)
   );

   assign wb_en   = sel_ok && calc_wb;
   assign ea_addr = sel_ok ? calc_addr : '0;

   ptr_reg_bank #(
      .NREG(NREG), .DW(DW), .AW(AW), .NPTR(NPTR), .PTR_BASE(PTR_BASE),
      .IDXW(IDXW), .SELW(SELW)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .wb_en    (wb_en),
      .wb_sel   (ea_sel),
      .wb_val   (calc_next),
      .rd_idx   (rd_idx),
      .rd_data  (rd_data),
      .ptr_flat (ptr_flat)
   );

endmodule

// File: rtl/ptr_unit_checker.sv
module ptr_unit_checker #(
   parameter int NREG     = 32,
   parameter int AW       = 16,
   parameter int NPTR     = 3,
   parameter int PTR_BASE = 26,
   parameter int IDXW     = 5,
   parameter int SELW     = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [IDXW-1:0]   wr_idx,
   input logic              ea_valid,
   input logic [SELW-1:0]   ea_sel,
   input logic [1:0]        ea_mode,
   input logic [AW-1:0]     ea_addr,
   input logic [NPTR*AW-1:0] ptr_flat
);

   logic          active;
   logic          pair_written;
   logic [AW-1:0] ptr_now;
   logic [AW-1:0] ptr_pick;
   logic          inc_q, dec_q, hold_q;
   logic [SELW-1:0] sel_q;
   logic [AW-1:0] addr_q, prev_q;

   assign active = ea_valid && (32'(ea_sel) < NPTR);
   assign pair_written = wr_en &&
      ((32'(wr_idx) == PTR_BASE + 2 * 32'(ea_sel)) ||
       (32'(wr_idx) == PTR_BASE + 2 * 32'(ea_sel) + 1));

   always_comb begin
      ptr_now  = '0;
      ptr_pick = '0;
      for (int p = 0; p < NPTR; p++) begin
         if (ea_sel == SELW'(p)) ptr_now  = ptr_flat[p*AW +: AW];
         if (sel_q  == SELW'(p)) ptr_pick = ptr_flat[p*AW +: AW];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inc_q  <= 1'b0;
         dec_q  <= 1'b0;
         hold_q <= 1'b0;
         sel_q  <= '0;
         addr_q <= '0;
         prev_q <= '0;
      end else begin
         inc_q  <= active && (ea_mode == 2'd2);
         dec_q  <= active && (ea_mode == 2'd3);
         hold_q <= active && !ea_mode[1] && !pair_written;
         sel_q  <= ea_sel;
         addr_q <= ea_addr;
         prev_q <= ptr_now;
      end
   end

   assert_postinc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      inc_q |-> ptr_pick == AW'(addr_q + AW'(1)))
      else $error("post-increment write-back wrong");

   assert_predec_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dec_q |-> ptr_pick == addr_q)
      else $error("pre-decrement write-back wrong");

   assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hold_q |-> ptr_pick == prev_q)
      else $error("pointer changed in a non-updating mode");

   assert_idle_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> ea_addr == '0)
      else $error("address driven without a valid request");

   assert_wb_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (active && ea_mode[1] && pair_written) |=> ptr_pick == prev_q + (dec_q ? '1 : AW'(1)))
      else $error("byte write overrode pointer write-back");

endmodule

bind ptr_reg_unit ptr_unit_checker #(
   .NREG(NREG), .AW(AW), .NPTR(NPTR), .PTR_BASE(PTR_BASE),
   .IDXW(IDXW), .SELW(SELW)
) u_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_idx   (wr_idx),
   .ea_valid (ea_valid),
   .ea_sel   (ea_sel),
   .ea_mode  (ea_mode),
   .ea_addr  (ea_addr),
   .ptr_flat (ptr_flat)
);

// File: tb/tb_ptr_reg_unit.sv
module tb_ptr_reg_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_idx = '0;
   logic [7:0]  wr_data = '0;
   logic [4:0]  rd_idx = '0;
   logic [7:0]  rd_data;
   logic        ea_valid = 1'b0;
   logic [1:0]  ea_sel = '0;
   logic [1:0]  ea_mode = '0;
   logic [5:0]  ea_disp = '0;
   logic [15:0] ea_addr;

   int checks = 0;
   int errors = 0;
   logic [7:0] model [32];

   always #10 clk = ~clk;

   ptr_reg_unit dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_data(rd_data), .ea_valid(ea_valid), .ea_sel(ea_sel),
      .ea_mode(ea_mode), .ea_disp(ea_disp), .ea_addr(ea_addr)
   );

   function automatic logic [15:0] ptr_of(input logic [1:0] s);
      return {model[27 + 2*s], model[26 + 2*s]};
   endfunction

   function automatic logic [15:0] exp_addr(input logic v, input logic [1:0] s,
                                            input logic [1:0] m, input logic [5:0] d);
      logic [15:0] p;
      if (!v || s == 2'd3) return 16'h0000;
      p = ptr_of(s);
      case (m)
         2'd1:    return p + {10'd0, d};
         2'd3:    return p - 16'd1;
         default: return p;
      endcase
   endfunction

   function automatic string tag_of(input logic v, input logic [1:0] s, input logic [1:0] m);
      if (!v || s == 2'd3) return "R7";
      case (m)
         2'd0: return "R3";
         2'd1: return "R4";
         2'd2: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one cycle: drive, check combinational outputs, clock, update model
   task automatic step(input logic we, input logic [4:0] wi, input logic [7:0] wd,
                       input logic [4:0] ri, input logic v, input logic [1:0] s,
                       input logic [1:0] m, input logic [5:0] d);
      logic [15:0] a;
      logic [15:0] np;
      @(negedge clk);
      wr_en = we; wr_idx = wi; wr_data = wd; rd_idx = ri;
      ea_valid = v; ea_sel = s; ea_mode = m; ea_disp = d;
      #3;
      a = exp_addr(v, s, m, d);
      check("R2 read", {8'h00, rd_data}, {8'h00, model[ri]});
      check(tag_of(v, s, m), ea_addr, a);
      np = (m == 2'd2) ? ptr_of(s) + 16'd1 : a;
      @(posedge clk);
      #1;
      if (we) model[wi] = wd;
      // R8: write-back applied after the byte write so it wins
      if (v && s != 2'd3 && m[1]) begin
         model[26 + 2*s] = np[7:0];
         model[27 + 2*s] = np[15:8];
      end
      wr_en = 1'b0; ea_valid = 1'b0;
   endtask

   task automatic set_ptr(input logic [1:0] s, input logic [15:0] val);
      step(1'b1, 5'(26 + 2*s), val[7:0], 5'd0, 1'b0, 2'd0, 2'd0, 6'd0);
      step(1'b1, 5'(27 + 2*s), val[15:8], 5'd0, 1'b0, 2'd0, 2'd0, 6'd0);
   endtask

   task automatic read_ptr(input string req, input logic [1:0] s, input logic [15:0] exp);
      logic [7:0] lo;
      step(1'b0, 5'(26 + 2*s), 8'h00, 5'(26 + 2*s), 1'b0, 2'd0, 2'd0, 6'd0);
      lo = rd_data;
      step(1'b0, 5'(27 + 2*s), 8'h00, 5'(27 + 2*s), 1'b0, 2'd0, 2'd0, 6'd0);
      check(req, {rd_data, lo}, exp);
   endtask

   initial begin : watchdog
      #2000000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      int unsigned seed;
      for (int k = 0; k < 32; k++) model[k] = 8'h00;
      seed = 32'h1234_5678;
      void'($urandom(seed));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: every register reads zero after reset
      for (int k = 0; k < 32; k++) begin
         @(negedge clk); rd_idx = 5'(k); #3;
         check("R1", {8'h00, rd_data}, 16'h0000);
      end

      // R3: byte pair mapping, then plain mode
      set_ptr(2'd0, 16'h1234);
      set_ptr(2'd1, 16'hABCD);
      set_ptr(2'd2, 16'h00FF);
      step(1'b0, 5'd0, 8'h00, 5'd27, 1'b1, 2'd0, 2'd0, 6'd0);
      step(1'b0, 5'd0, 8'h00, 5'd29, 1'b1, 2'd1, 2'd0, 6'd0);
      read_ptr("R3 plain hold", 2'd1, 16'hABCD);

      // R5: carry from low into high byte, then wrap at the top
      step(1'b0, 5'd0, 8'h00, 5'd0, 1'b1, 2'd2, 2'd2, 6'd0);
      read_ptr("R5 carry", 2'd2, 16'h0100);
      set_ptr(2'd2, 16'hFFFF);
      step(1'b0, 5'd0, 8'h00, 5'd0, 1'b1, 2'd2, 2'd2, 6'd0);
      read_ptr("R5 wrap", 2'd2, 16'h0000);

      // R6: borrow and wrap below zero
      step(1'b0, 5'd0, 8'h00, 5'd0, 1'b1, 2'd2, 2'd3, 6'd0);
      read_ptr("R6 wrap", 2'd2, 16'hFFFF);
      set_ptr(2'd0, 16'h0100);
      step(1'b0, 5'd0, 8'h00, 5'd0, 1'b1, 2'd0, 2'd3, 6'd0);
      read_ptr("R6 borrow", 2'd0, 16'h00FF);

      // R4: offset overflows past 0xFFFF, pointer stays
      set_ptr(2'd1, 16'hFFF0);
      step(1'b0, 5'd0, 8'h00, 5'd0, 1'b1, 2'd1, 2'd1, 6'h3F);
      read_ptr("R4 hold", 2'd1, 16'hFFF0);

      // R7: invalid select and valid low leave pointers alone
      step(1'b0, 5'd0, 8'h00, 5'd0, 1'b1, 2'd3, 2'd2, 6'd5);
      step(1'b0, 5'd0, 8'h00, 5'd0, 1'b0, 2'd1, 2'd3, 6'd5);
      read_ptr("R7 no change", 2'd1, 16'hFFF0);

      // R8: write-back beats a byte write to the same register
      set_ptr(2'd0, 16'h20FF);
      step(1'b1, 5'd26, 8'hAA, 5'd0, 1'b1, 2'd0, 2'd2, 6'd0);
      read_ptr("R8 wb wins", 2'd0, 16'h2100);
      // R8: byte write outside the active pair still lands
      step(1'b1, 5'd5, 8'h5A, 5'd0, 1'b1, 2'd0, 2'd3, 6'd0);
      step(1'b0, 5'd0, 8'h00, 5'd5, 1'b0, 2'd0, 2'd0, 6'd0);
      check("R8 other reg", {8'h00, rd_data}, 16'h005A);

      // constrained random mix, biased toward pointer registers
      for (int n = 0; n < 3000; n++) begin
         logic [4:0] wi;
         logic [4:0] ri;
         wi = ($urandom % 4 != 0) ? 5'(26 + $urandom % 6) : 5'($urandom % 32);
         ri = ($urandom % 2 != 0) ? 5'(26 + $urandom % 6) : 5'($urandom % 32);
         step(($urandom % 3) == 0, wi, 8'($urandom), ri,
              ($urandom % 4) != 0, 2'($urandom), 2'($urandom), 6'($urandom));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule